// File: doc/BRIEF.md
# Vector register group legality checker

This block decides, in pure combinational logic, whether the register operands of a vector load form a legal combination. It looks at the destination base register, the number of registers in each data group and the number of fields per segment. It then raises a single illegal-instruction flag when the destination is misaligned, when it runs past the last architectural register, or when a masked load would write the mask register.

For indexed loads the block also compares the destination span against the index source group. When the two groups overlap, the widths of data and index elements decide whether that is allowed. With equal widths the overlap is legal. With narrower data the destination must start on the index base. With wider data the index group multiplier must be at least one whole register and both groups must end on the same register. Indexed segment loads allow no overlap at all. The decode stage uses the flag to turn the load into an illegal-instruction trap. Memory access and trap delivery happen elsewhere.

Top module: `vreg_group_legal`

## Requirements
- R1: The flag is set when `vd_i` is not a multiple of `data_regs_i` (group sizes are 1, 2, 4 or 8).
- R2: The flag is set when `vd_i + (nf_m1_i + 1) * data_regs_i` exceeds 32. The field count is `nf_m1_i + 1`, from 1 to 8.
- R3: The flag is set when `mask_en_i` is 1 and `vd_i` is 0.
- R4: For an indexed load (`indexed_i` = 1), a destination span `[vd, vd + fields*data_regs)` that does not overlap `[vs2, vs2 + idx_regs)` never sets the flag on its own.
- R5: For a non-segment indexed load with overlap, equal data and index widths are legal. Width codes on `sew_i` and `idx_ew_i`: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R6: For a non-segment indexed load with overlap and a data width smaller than the index width, the overlap is legal only when `vd_i == vs2_i`.
- R7: For a non-segment indexed load with overlap and a data width larger than the index width, the overlap is legal only when both conditions hold: `idx_width * lmul_num_i >= sew * lmul_den_i`, and `vd_i + data_regs_i == vs2_i + idx_regs_i`.
- R8: For an indexed segment load (field count above 1), any overlap of the destination span with the index group sets the flag.
- R9: When `indexed_i` is 0, the index operands and widths have no effect on the flag.
- R10: The flag is combinational and follows its inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vd_i | input | 5 | Destination base register |
| data_regs_i | input | 4 | Registers per data field group (1, 2, 4, 8) |
| nf_m1_i | input | 3 | Field count minus one |
| mask_en_i | input | 1 | Load is masked by register 0 |
| indexed_i | input | 1 | Load is indexed; enables the overlap rules |
| vs2_i | input | 5 | Index source base register |
| idx_regs_i | input | 4 | Registers in the index group |
| idx_ew_i | input | 2 | Index element width code |
| sew_i | input | 2 | Selected (data) element width code |
| lmul_num_i | input | 4 | Group multiplier numerator |
| lmul_den_i | input | 4 | Group multiplier denominator |
| illegal_o | output | 1 | Operand combination is illegal |

## Verification
Directed cases separate the three destination faults from one another: a misaligned base, a span that ends exactly at 32 against one that ends past it, and a masked base at 0 against one at 1. Overlap cases pair each width relation with one legal and one illegal placement. For wider data, a fractional index multiplier is also tried with otherwise matching group ends. This shows that the exact multiplier product is tested rather than the register count alone. Segment cases put the index group just inside and just outside the last field. A non-indexed load with clashing index operands shows that those operands are ignored. A long run of constrained-random operand sets, biased toward shared base registers, is then compared cycle by cycle against a behavioural model.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  localparam int unsigned NUM_VREGS = 32;
  typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_e;
endpackage

// File: rtl/vgc_dst_chk.sv
module vgc_dst_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned NF_W   = 3,
  parameter int unsigned SPAN_W = NF_W + 1 + GRP_W
) (
  input  logic [REG_W-1:0]  vd_i,
  input  logic [GRP_W-1:0]  data_regs_i,
  input  logic [NF_W-1:0]   nf_m1_i,
  input  logic              mask_en_i,
  output logic [SPAN_W-1:0] span_o,
  output logic              misalign_o,
  output logic              oob_o,
  output logic              mask_hit_o
);
  localparam int unsigned END_W = ((SPAN_W > REG_W) ? SPAN_W : REG_W) + 1;

  logic [REG_W-1:0] low_bits;
  logic [END_W-1:0] span_end;

  always_comb begin
    low_bits   = REG_W'(data_regs_i - 1'b1);
    misalign_o = |(vd_i & low_bits);
    span_o     = SPAN_W'(SPAN_W'(nf_m1_i) + 1'b1) * SPAN_W'(data_regs_i);
    span_end   = END_W'(vd_i) + END_W'(span_o);
    oob_o      = span_end > END_W'(vgc_pkg::NUM_VREGS);
    mask_hit_o = mask_en_i && (vd_i == '0);
  end

  always_comb begin
    if (mask_en_i && vd_i == '0) AST_MASK_BASE_HIT: assert (mask_hit_o); // R3
  end
endmodule

// File: rtl/vgc_range_ovl.sv
module vgc_range_ovl #(
  parameter int unsigned BASE_W = 5,
  parameter int unsigned LEN_W  = 8
) (
  input  logic [BASE_W-1:0] a_base_i,
  input  logic [LEN_W-1:0]  a_len_i,
  input  logic [BASE_W-1:0] b_base_i,
  input  logic [LEN_W-1:0]  b_len_i,
  output logic              ovl_o
);
  localparam int unsigned SUM_W = ((LEN_W > BASE_W) ? LEN_W : BASE_W) + 1;

  logic [SUM_W-1:0] a_end, b_end;

  always_comb begin
    a_end = SUM_W'(a_base_i) + SUM_W'(a_len_i);
    b_end = SUM_W'(b_base_i) + SUM_W'(b_len_i);
    ovl_o = (SUM_W'(a_base_i) < b_end) && (SUM_W'(b_base_i) < a_end);
  end
endmodule

// File: rtl/vgc_mixw_chk.sv
module vgc_mixw_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned EW_W   = 2,
  parameter int unsigned LMUL_W = 4
) (
  input  logic [REG_W-1:0]  vd_i,
  input  logic [GRP_W-1:0]  data_regs_i,
  input  logic [REG_W-1:0]  vs2_i,
  input  logic [GRP_W-1:0]  idx_regs_i,
  input  logic [EW_W-1:0]   sew_i,
  input  logic [EW_W-1:0]   idx_ew_i,
  input  logic [LMUL_W-1:0] lmul_num_i,
  input  logic [LMUL_W-1:0] lmul_den_i,
  input  logic              ovl_i,
  input  logic              segment_i,
  output logic              bad_o
);
  localparam int unsigned SHIFT_MAX = (1 << EW_W) - 1;
  localparam int unsigned PROD_W    = LMUL_W + SHIFT_MAX;
  localparam int unsigned END_W     = ((GRP_W > REG_W) ? GRP_W : REG_W) + 1;

  logic [PROD_W-1:0] idx_side, dat_side;
  logic              emul_ge1, ends_eq, narrow_bad, wide_bad;

  always_comb begin
    // widths are 8 << code, so the common factor of 8 cancels
    idx_side   = PROD_W'(lmul_num_i) << idx_ew_i;
    dat_side   = PROD_W'(lmul_den_i) << sew_i;
    emul_ge1   = idx_side >= dat_side;
    ends_eq    = (END_W'(vd_i) + END_W'(data_regs_i)) == (END_W'(vs2_i) + END_W'(idx_regs_i));
    narrow_bad = (sew_i < idx_ew_i) && (vd_i != vs2_i);
    wide_bad   = (sew_i > idx_ew_i) && !(emul_ge1 && ends_eq);
    bad_o      = ovl_i && (segment_i || narrow_bad || wide_bad);
  end

  always_comb begin
    if (!ovl_i) AST_NO_OVL_NO_BAD: assert (!bad_o); // R4
    if (ovl_i && segment_i) AST_SEG_OVL_BAD: assert (bad_o); // R8
    if (ovl_i && !segment_i && sew_i == idx_ew_i) AST_SAME_EW_OK: assert (!bad_o); // R5
    if (ovl_i && !segment_i && sew_i < idx_ew_i && vd_i == vs2_i)
      AST_NARROW_BASE_OK: assert (!bad_o); // R6
  end
endmodule

// File: rtl/vreg_group_legal.sv
module vreg_group_legal #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned NF_W   = 3,
  parameter int unsigned EW_W   = 2,
  parameter int unsigned LMUL_W = 4
) (
  input  logic [REG_W-1:0]  vd_i,
  input  logic [GRP_W-1:0]  data_regs_i,
  input  logic [NF_W-1:0]   nf_m1_i,
  input  logic              mask_en_i,
  input  logic              indexed_i,
  input  logic [REG_W-1:0]  vs2_i,
  input  logic [GRP_W-1:0]  idx_regs_i,
  input  logic [EW_W-1:0]   idx_ew_i,
  input  logic [EW_W-1:0]   sew_i,
  input  logic [LMUL_W-1:0] lmul_num_i,
  input  logic [LMUL_W-1:0] lmul_den_i,
  output logic              illegal_o
);
  localparam int unsigned SPAN_W = NF_W + 1 + GRP_W;

  logic [SPAN_W-1:0] span;
  logic misalign, oob, mask_hit, ovl, idx_bad, segment;

  assign segment = nf_m1_i != '0;

  vgc_dst_chk #(.REG_W(REG_W), .GRP_W(GRP_W), .NF_W(NF_W), .SPAN_W(SPAN_W)) i_dst (
    .vd_i(vd_i), .data_regs_i(data_regs_i), .nf_m1_i(nf_m1_i), .mask_en_i(mask_en_i),
    .span_o(span), .misalign_o(misalign), .oob_o(oob), .mask_hit_o(mask_hit)
  );

  vgc_range_ovl #(.BASE_W(REG_W), .LEN_W(SPAN_W)) i_ovl (
    .a_base_i(vd_i), .a_len_i(span), .b_base_i(vs2_i),
    .b_len_i(SPAN_W'(idx_regs_i)), .ovl_o(ovl)
  );

  vgc_mixw_chk #(.REG_W(REG_W), .GRP_W(GRP_W), .EW_W(EW_W), .LMUL_W(LMUL_W)) i_mixw (
    .vd_i(vd_i), .data_regs_i(data_regs_i), .vs2_i(vs2_i), .idx_regs_i(idx_regs_i),
    .sew_i(sew_i), .idx_ew_i(idx_ew_i), .lmul_num_i(lmul_num_i), .lmul_den_i(lmul_den_i),
    .ovl_i(ovl), .segment_i(segment), .bad_o(idx_bad)
  );

  assign illegal_o = misalign || oob || mask_hit || (indexed_i && idx_bad);

  always_comb begin
    if (data_regs_i != '0 && (int'(vd_i) % int'(data_regs_i)) != 0)
      AST_ALIGN_FLAG: assert (illegal_o); // R1
    if (int'(vd_i) + (int'(nf_m1_i) + 1) * int'(data_regs_i) > 32)
      AST_BOUND_FLAG: assert (illegal_o); // R2
    if (mask_en_i && vd_i == '0) AST_MASK_FLAG: assert (illegal_o); // R3
    if (!indexed_i && !misalign && !oob && !mask_hit)
      AST_PLAIN_LEGAL: assert (!illegal_o); // R9
  end
endmodule

// File: tb/test_vreg_group_legal.sv
module test_vreg_group_legal;
  logic       clk = 1'b0;
  logic [4:0] vd, vs2;
  logic [3:0] dregs, iregs, lnum, lden;
  logic [2:0] nfm1;
  logic [1:0] iew, sew;
  logic       msk, idx, illegal;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  vreg_group_legal i_vreg_group_legal (
    .vd_i(vd), .data_regs_i(dregs), .nf_m1_i(nfm1), .mask_en_i(msk), .indexed_i(idx),
    .vs2_i(vs2), .idx_regs_i(iregs), .idx_ew_i(iew), .sew_i(sew),
    .lmul_num_i(lnum), .lmul_den_i(lden), .illegal_o(illegal)
  );

  function automatic bit model(output string tag);
    int nf = int'(nfm1) + 1;
    int span = nf * int'(dregs);
    int db = 8 << sew, ib = 8 << iew;
    if (int'(vd) % int'(dregs) != 0) begin tag = "R1"; return 1'b1; end
    if (int'(vd) + span > 32) begin tag = "R2"; return 1'b1; end
    if (msk && vd == 0) begin tag = "R3"; return 1'b1; end
    if (!idx) begin tag = "R9"; return 1'b0; end
    if (!(int'(vd) < int'(vs2) + int'(iregs) && int'(vs2) < int'(vd) + span)) begin
      tag = "R4"; return 1'b0;
    end
    if (nf > 1) begin tag = "R8"; return 1'b1; end
    if (db == ib) begin tag = "R5"; return 1'b0; end
    if (db < ib) begin tag = "R6"; return vd != vs2; end
    tag = "R7";
    return !((ib * int'(lnum) >= db * int'(lden)) &&
             (int'(vd) + int'(dregs) == int'(vs2) + int'(iregs)));
  endfunction

  task automatic set_ops(input int a_vd, input int a_dr, input int a_nf, input bit a_m,
                         input bit a_ix, input int a_vs2, input int a_ir, input int a_iew,
                         input int a_sew, input int a_num, input int a_den);
    vd = 5'(a_vd); dregs = 4'(a_dr); nfm1 = 3'(a_nf - 1); msk = a_m; idx = a_ix;
    vs2 = 5'(a_vs2); iregs = 4'(a_ir); iew = 2'(a_iew); sew = 2'(a_sew);
    lnum = 4'(a_num); lden = 4'(a_den);
  endtask

  task automatic check(input bit exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (illegal !== exp) begin
      n_fail++;
      $display("FAIL %s: illegal_o=%b expected %b (vd=%0d dregs=%0d nf=%0d vs2=%0d iregs=%0d)",
               tag, illegal, exp, vd, dregs, nfm1 + 1, vs2, iregs);
    end
  endtask

  task automatic apply(input int a_vd, input int a_dr, input int a_nf, input bit a_m,
                       input bit a_ix, input int a_vs2, input int a_ir, input int a_iew,
                       input int a_sew, input int a_num, input int a_den,
                       input bit exp, input string tag);
    @(posedge clk); #1;
    set_ops(a_vd, a_dr, a_nf, a_m, a_ix, a_vs2, a_ir, a_iew, a_sew, a_num, a_den);
    check(exp, tag);
  endtask

  initial begin
    set_ops(0, 1, 1, 0, 0, 0, 1, 0, 0, 1, 1);
    check(1'b0, "R9 default");
    // R1 misaligned base
    apply(2, 4, 1, 0, 0, 0, 1, 0, 0, 1, 1, 1'b1, "R1");
    apply(4, 4, 1, 0, 0, 0, 1, 0, 0, 1, 1, 1'b0, "R1");
    // R2 bound: 24+8=32 legal, 24+16 illegal
    apply(24, 8, 1, 0, 0, 0, 1, 0, 0, 1, 1, 1'b0, "R2");
    apply(24, 8, 2, 0, 0, 0, 1, 0, 0, 1, 1, 1'b1, "R2");
    // R3 mask on register 0
    apply(0, 1, 1, 1, 0, 0, 1, 0, 0, 1, 1, 1'b1, "R3");
    apply(1, 1, 1, 1, 0, 0, 1, 0, 0, 1, 1, 1'b0, "R3");
    // R4 disjoint indexed
    apply(8, 2, 1, 0, 1, 16, 2, 0, 3, 1, 1, 1'b0, "R4");
    // R5 equal widths overlapping
    apply(16, 2, 1, 0, 1, 16, 2, 2, 2, 2, 1, 1'b0, "R5");
    // R6 narrower data
    apply(4, 1, 1, 0, 1, 4, 4, 2, 0, 1, 1, 1'b0, "R6");
    apply(5, 1, 1, 0, 1, 4, 4, 2, 0, 1, 1, 1'b1, "R6");
    // R7 wider data, LMUL 8, index EMUL 2
    apply(8, 8, 1, 0, 1, 14, 2, 1, 3, 8, 1, 1'b0, "R7");
    apply(8, 8, 1, 0, 1, 12, 2, 1, 3, 8, 1, 1'b1, "R7");
    // R7 fractional index EMUL with matching ends
    apply(4, 1, 1, 0, 1, 4, 1, 1, 3, 1, 1, 1'b1, "R7");
    // R8 segment overlap
    apply(8, 2, 2, 0, 1, 10, 1, 1, 1, 1, 1, 1'b1, "R8");
    apply(8, 2, 2, 0, 1, 12, 1, 1, 1, 1, 1, 1'b0, "R8");
    // R9 index operands ignored on a plain load
    apply(8, 8, 1, 0, 0, 12, 2, 1, 3, 1, 8, 1'b0, "R9");
    // R10 random operand sets, checked every cycle
    for (int k = 0; k < 3000; k++) begin
      int e, dr, nf, v;
      string tag;
      bit exp;
      @(posedge clk); #1;
      e  = $urandom_range(0, 6) - 3;
      dr = 1 << $urandom_range(0, 3);
      nf = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 8) : 1;
      v  = $urandom_range(0, 3) == 0 ? $urandom_range(0, 31) : dr * $urandom_range(0, 32 / dr - 1);
      set_ops(v, dr, nf, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
              ($urandom_range(0, 2) == 0) ? v : $urandom_range(0, 31),
              1 << $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
              (e > 0) ? (1 << e) : 1, (e < 0) ? (1 << -e) : 1);
      exp = model(tag);
      check(exp, {tag, " R10"});
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete=1 expected 0");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule